// File: doc/BRIEF.md
# Keyed Configuration Port Controller

This block is the configuration front end of a peripheral controller that sits on a byte-wide I/O bus as two adjacent ports. One port is an index and the other is a data window. After reset, configuration space is closed. Software opens it by writing a fixed four-byte key to the index port. The last key byte depends on whether the instance is strapped at the primary or the alternate port address.

Once the port is open, a write to the index port selects a register, and the data port reads or writes that register. The register space has these parts:

- a pair of read-only identification bytes;
- a flash-decode control byte;
- a logical-device selector;
- one bank per logical device, each holding a 16-bit base address.

The flash-decode bits and the base address of the serial-flash engine's bank are exported to the rest of the chip. A dedicated exit write closes the port again.

Top module: `cfg_port_ctrl`

## Requirements
- R1: After reset the port is locked, the index is 0x00, the device select is 0, the flash-decode byte is 0x00 and every bank base is 0x0000, so both ports read 0xFF, `flash_cfg_o` is 0 and `spi_base_o` is 0.
- R2: Writing 0x87, 0x01, 0x55, K to the index port (`addr_i`=0) opens the port, where K is 0x55 when `ALT_PORT`=0 and 0xAA when `ALT_PORT`=1. Any other K leaves it locked.
- R3: A byte that breaks the key sequence returns the matcher to its start. If that byte is 0x87, it counts as the first key byte.
- R4: While locked, both ports read 0xFF. Data-port writes (`addr_i`=1) change no register, and key writes do not change the index.
- R5: While open, an index-port write sets the index, and the index port reads it back.
- R6: Registers 0x20 and 0x21 read the high and low bytes of `CHIP_ID` (0x87, 0x16). Writes to them are ignored.
- R7: Register 0x24 holds six writable bits [5:0], which drive `flash_cfg_o`. Bits [7:6] read 0. The bit meanings are:
  - bit 0: suspend;
  - bit 1: the high pair of decode segments;
  - bits 2 and 3: two further segments;
  - bit 4: write enable;
  - bit 5: the alternate flash pin.
- R8: Register 0x07 is a read/write device select. Registers 0x64 (high) and 0x65 (low) access the 16-bit base of the selected bank, and banks are independent. A select of `NUM_LDN` or above reads 0x00 there and ignores writes.
- R9: `spi_base_o` always equals the base held in bank `SPI_LDN` (7).
- R10: Writing 0x02 to register 0x02 relocks the port and keeps all register contents. Any other value written there has no effect, and register 0x02 reads 0x00.
- R11: Indices that are not implemented read 0x00 while the port is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe, one byte per cycle |
| addr_i | input | 1 | 0 selects the index port, 1 selects the data port |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the port selected by `addr_i` (combinational) |
| flash_cfg_o | output | 6 | Flash-decode control bits |
| spi_base_o | output | 16 | Base address held in the serial-flash engine's bank |

## Verification
The bench sweeps every value of the fourth key byte on a primary and an alternate instance. A design that compared against the wrong last byte would open on the other port's key or on none. Restart cases (a repeated 0x87, and a 0x87 in place of a later byte) catch a matcher that drops to idle without re-arming, which would need one more key byte than it should. Banks are written past the implemented count and read back in a full index sweep. Aliasing, writes leaking into neighbouring banks or out-of-range selects, and non-zero reads of holes would all show up there. The exit register is probed with a wrong value first, and contents are checked to survive the relock and a second unlock.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  typedef enum logic [2:0] {KS_IDLE, KS_B1, KS_B2, KS_B3, KS_OPEN} key_state_e;

  localparam logic [7:0] KEY_B0     = 8'h87;
  localparam logic [7:0] KEY_B1     = 8'h01;
  localparam logic [7:0] KEY_B2     = 8'h55;
  localparam logic [7:0] KEY_B3_PRI = 8'h55;
  localparam logic [7:0] KEY_B3_ALT = 8'hAA;

  localparam logic [7:0] REG_EXIT    = 8'h02;
  localparam logic [7:0] REG_LDN     = 8'h07;
  localparam logic [7:0] REG_ID_HI   = 8'h20;
  localparam logic [7:0] REG_ID_LO   = 8'h21;
  localparam logic [7:0] REG_FLASH   = 8'h24;
  localparam logic [7:0] REG_BASE_HI = 8'h64;
  localparam logic [7:0] REG_BASE_LO = 8'h65;
  localparam logic [7:0] EXIT_CODE   = 8'h02;
endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
  import cfg_port_pkg::*;
#(
  parameter bit ALT_PORT = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       key_we_i,
  input  logic [7:0] key_i,
  input  logic       relock_i,
  output logic       open_o
);
  localparam logic [7:0] KeyLast = ALT_PORT ? KEY_B3_ALT : KEY_B3_PRI;

  key_state_e state_q, state_d;
  logic [7:0] expect_b;

  always_comb begin
    unique case (state_q)
      KS_B1:   expect_b = KEY_B1;
      KS_B2:   expect_b = KEY_B2;
      KS_B3:   expect_b = KeyLast;
      default: expect_b = KEY_B0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    if (state_q == KS_OPEN) begin
      if (relock_i) state_d = KS_IDLE;
    end else if (key_we_i) begin
      if (key_i == expect_b) begin
        unique case (state_q)
          KS_IDLE: state_d = KS_B1;
          KS_B1:   state_d = KS_B2;
          KS_B2:   state_d = KS_B3;
          default: state_d = KS_OPEN;
        endcase
      end else if (key_i == KEY_B0) begin
        state_d = KS_B1;  // broken sequence re-arms on a first byte
      end else begin
        state_d = KS_IDLE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= KS_IDLE;
    else         state_q <= state_d;
  end

  assign open_o = (state_q == KS_OPEN);

  a_r2_open_after_last_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> $past(key_we_i && key_i == KeyLast));

  a_r3_short_key_stays_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_we_i && state_q != KS_B3 && state_q != KS_OPEN) |=> !open_o);

  a_r10_relock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_o && relock_i) |=> !open_o);
endmodule

// File: rtl/cfg_ldn_bank.sv
module cfg_ldn_bank #(
  parameter int          BASE_W = 16,
  parameter logic [7:0]  MY_LDN = 8'd0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        sel_ldn_i,
  input  logic              we_hi_i,
  input  logic              we_lo_i,
  input  logic [7:0]        wdata_i,
  output logic [BASE_W-1:0] base_o
);
  localparam int HiW = BASE_W - 8;

  logic hit;
  assign hit = (sel_ldn_i == MY_LDN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
    end else if (hit) begin
      if (we_hi_i) base_o[BASE_W-1:8] <= wdata_i[HiW-1:0];
      if (we_lo_i) base_o[7:0]        <= wdata_i;
    end
  end

  a_r8_bank_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_ldn_i != MY_LDN) |=> $stable(base_o));
endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
  import cfg_port_pkg::*;
#(
  parameter bit          ALT_PORT = 1'b0,
  parameter logic [15:0] CHIP_ID  = 16'h8716,
  parameter int          NUM_LDN  = 8,
  parameter int          SPI_LDN  = 7,
  parameter int          FLASH_W  = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               addr_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  output logic [FLASH_W-1:0] flash_cfg_o,
  output logic [15:0]        spi_base_o
);
  localparam int LdnIw = (NUM_LDN > 1) ? $clog2(NUM_LDN) : 1;

  logic       open;
  logic [7:0] idx_q, ldn_q;
  logic       idx_we, data_we, relock, ldn_valid;
  logic [15:0] bank_base [NUM_LDN];
  logic [15:0] sel_base;

  assign idx_we    = wr_en_i && !addr_i;
  assign data_we   = wr_en_i && addr_i && open;
  assign relock    = data_we && (idx_q == REG_EXIT) && (wdata_i == EXIT_CODE);
  assign ldn_valid = (int'(ldn_q) < NUM_LDN);

  cfg_key_fsm #(.ALT_PORT(ALT_PORT)) u_key (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .key_we_i (idx_we && !open),
    .key_i    (wdata_i),
    .relock_i (relock),
    .open_o   (open)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q       <= '0;
      ldn_q       <= '0;
      flash_cfg_o <= '0;
    end else begin
      if (idx_we && open) idx_q <= wdata_i;
      if (data_we && idx_q == REG_LDN) ldn_q <= wdata_i;
      if (data_we && idx_q == REG_FLASH) flash_cfg_o <= wdata_i[FLASH_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_LDN; g++) begin : g_bank
    cfg_ldn_bank #(.BASE_W(16), .MY_LDN(8'(g))) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sel_ldn_i (ldn_q),
      .we_hi_i   (data_we && idx_q == REG_BASE_HI),
      .we_lo_i   (data_we && idx_q == REG_BASE_LO),
      .wdata_i   (wdata_i),
      .base_o    (bank_base[g])
    );
  end

  assign sel_base   = ldn_valid ? bank_base[ldn_q[LdnIw-1:0]] : 16'h0000;
  assign spi_base_o = bank_base[SPI_LDN];

  always_comb begin
    rdata_o = 8'hFF;
    if (open) begin
      if (!addr_i) begin
        rdata_o = idx_q;
      end else begin
        unique case (idx_q)
          REG_ID_HI:   rdata_o = CHIP_ID[15:8];
          REG_ID_LO:   rdata_o = CHIP_ID[7:0];
          REG_LDN:     rdata_o = ldn_q;
          REG_FLASH:   rdata_o = 8'(flash_cfg_o);
          REG_BASE_HI: rdata_o = sel_base[15:8];
          REG_BASE_LO: rdata_o = sel_base[7:0];
          default:     rdata_o = 8'h00;
        endcase
      end
    end
  end

  a_r4_locked_writes_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open && wr_en_i) |=> ($stable(flash_cfg_o) && $stable(spi_base_o) && $stable(ldn_q)));

  a_r4_locked_index_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open |=> $stable(idx_q));

  a_r7_flash_write_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(flash_cfg_o) |-> $past(data_we && idx_q == REG_FLASH));

  a_r10_relock_keeps_regs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    relock |=> ($stable(flash_cfg_o) && $stable(spi_base_o)));
endmodule

// File: tb/test_cfg_port_ctrl.sv
module test_cfg_port_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata, rdata_alt;
  logic [5:0] flash_cfg, flash_cfg_alt;
  logic [15:0] spi_base, spi_base_alt;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cfg_port_ctrl #(.ALT_PORT(1'b0)) i_cfg_port_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .flash_cfg_o(flash_cfg), .spi_base_o(spi_base));

  cfg_port_ctrl #(.ALT_PORT(1'b1)) i_cfg_port_ctrl_alt (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata_alt), .flash_cfg_o(flash_cfg_alt), .spi_base_o(spi_base_alt));

  // reference state of the primary instance
  bit         m_open;
  int         m_k;
  logic [7:0] m_idx, m_ldn;
  logic [5:0] m_cfg;
  logic [15:0] m_base [16];

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; addr = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_open = 0; m_k = 0; m_idx = 0; m_ldn = 0; m_cfg = 0;
    for (int i = 0; i < 16; i++) m_base[i] = 16'h0;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    logic [7:0] ex;
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (!a) begin
      if (m_open) m_idx = d;
      else begin
        ex = (m_k == 0) ? 8'h87 : (m_k == 1) ? 8'h01 : 8'h55;
        if (d == ex) begin
          m_k++;
          if (m_k == 4) begin m_open = 1; m_k = 0; end
        end else m_k = (d == 8'h87) ? 1 : 0;
      end
    end else if (m_open) begin
      case (m_idx)
        8'h02: if (d == 8'h02) m_open = 0;
        8'h07: m_ldn = d;
        8'h24: m_cfg = d[5:0];
        8'h64: if (m_ldn < 8) m_base[m_ldn[3:0]][15:8] = d;
        8'h65: if (m_ldn < 8) m_base[m_ldn[3:0]][7:0] = d;
        default: ;
      endcase
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic a);
    if (!m_open) return 8'hFF;
    if (!a) return m_idx;
    case (m_idx)
      8'h20: return 8'h87;
      8'h21: return 8'h16;
      8'h07: return m_ldn;
      8'h24: return {2'b00, m_cfg};
      8'h64: return (m_ldn < 8) ? m_base[m_ldn[3:0]][15:8] : 8'h00;
      8'h65: return (m_ldn < 8) ? m_base[m_ldn[3:0]][7:0] : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic rd_chk(input string req, input logic a);
    addr = a;
    #1;
    chk(req, rdata, exp_rd(a));
  endtask

  task automatic key(input logic [7:0] last);
    wr(0, 8'h87); wr(0, 8'h01); wr(0, 8'h55); wr(0, last);
  endtask

  task automatic reg_wr(input logic [7:0] r, input logic [7:0] d);
    wr(0, r); wr(1, d);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    addr = 0; #1 chk("R1 index locked", rdata, 8'hFF);
    addr = 1; #1 chk("R1 data locked", rdata, 8'hFF);
    chk("R1 flash_cfg", flash_cfg, 6'h0);
    chk("R1 spi_base", spi_base, 16'h0);

    // R2 sweep of the fourth key byte on both instances
    for (int v = 0; v < 256; v++) begin
      do_reset();
      key(8'(v));
      addr = 0; #1;
      chk("R2 primary key", rdata, (v == 8'h55) ? 8'h00 : 8'hFF);
      chk("R2 alternate key", rdata_alt, (v == 8'hAA) ? 8'h00 : 8'hFF);
    end

    // R3 restart behaviour
    do_reset(); wr(0, 8'h87); key(8'h55);
    addr = 0; #1 chk("R3 repeated first byte", rdata, 8'h00);
    do_reset(); wr(0, 8'h87); wr(0, 8'h01); key(8'h55);
    addr = 0; #1 chk("R3 restart at byte 3", rdata, 8'h00);
    do_reset(); wr(0, 8'h87); wr(0, 8'h01); wr(0, 8'h55); key(8'h55);
    addr = 0; #1 chk("R3 restart at byte 4", rdata, 8'h00);
    do_reset(); wr(0, 8'h87); wr(0, 8'h01); wr(0, 8'h00); wr(0, 8'h55); wr(0, 8'h55);
    addr = 0; #1 chk("R3 broken key idle", rdata, 8'hFF);

    // R4 locked accesses
    do_reset(); wr(0, 8'h87); wr(0, 8'h01);
    wr(1, 8'h3F); wr(1, 8'h02);
    addr = 1; #1 chk("R4 locked data read", rdata, 8'hFF);
    chk("R4 locked write flash", flash_cfg, 6'h0);
    wr(0, 8'h55); wr(0, 8'h55);
    rd_chk("R4 key writes left index", 0);
    chk("R4 index unmoved", rdata, 8'h00);

    // R5..R9, R11 while open
    reg_wr(8'h24, 8'hFF);
    rd_chk("R7 flash reg", 1);
    chk("R7 flash_cfg_o", flash_cfg, 6'h3F);
    reg_wr(8'h24, 8'hA5);
    rd_chk("R7 flash reg pattern", 1);
    chk("R7 flash_cfg_o pattern", flash_cfg, 6'h25);
    reg_wr(8'h20, 8'h00); rd_chk("R6 id high", 1);
    reg_wr(8'h21, 8'hFF); rd_chk("R6 id low", 1);
    wr(0, 8'h5A); rd_chk("R5 index readback", 0);
    for (int l = 0; l < 10; l++) begin
      reg_wr(8'h07, 8'(l));
      reg_wr(8'h64, 8'(l + 16));
      reg_wr(8'h65, ~8'(l));
    end
    for (int l = 0; l < 10; l++) begin
      reg_wr(8'h07, 8'(l));
      rd_chk("R8 ldn readback", 1);
      wr(0, 8'h64); rd_chk("R8 bank high", 1);
      chk("R8 bank high arith", rdata, (l < 8) ? 8'(l + 16) : 8'h00);
      wr(0, 8'h65); rd_chk("R8 bank low", 1);
    end
    chk("R9 spi_base_o", spi_base, {8'h17, 8'hF8});
    reg_wr(8'h07, 8'h03);
    for (int i = 0; i < 256; i++) begin
      wr(0, 8'(i));
      rd_chk("R11 index sweep", 1);
    end

    // R10 exit register
    reg_wr(8'h02, 8'h01);
    rd_chk("R10 wrong exit value", 0);
    chk("R10 still open", rdata, 8'h02);
    rd_chk("R10 exit reg reads zero", 1);
    wr(1, 8'h02);
    addr = 0; #1 chk("R10 relocked", rdata, 8'hFF);
    chk("R10 flash kept", flash_cfg, 6'h25);
    chk("R10 base kept", spi_base, 16'h17F8);
    key(8'h55);
    rd_chk("R10 reopen index", 0);
    wr(0, 8'h65); reg_wr(8'h07, 8'h07); wr(0, 8'h65);
    rd_chk("R10 bank kept", 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule